// File: doc/BRIEF.md
# Timer Compare Channel Bank with Pulse Output

This block holds a bank of compare channels that watch a free-running 31-bit nanosecond time value supplied by a neighbouring counter. Each channel owns a control/status register and a compare register. When the channel is armed and the time value equals its active compare value on a clock edge, the channel performs its output action, latches a sticky event flag, and can request an interrupt or a DMA transfer.

The compare register is double-buffered. While a channel is disabled, a write loads the active compare value directly. While it is armed, a write fills a single queued slot, and that slot becomes active on the next match. Software can therefore keep a periodic train such as one pulse per second going without a gap. To do this it writes, at each event, the value for the event after next. A global output-gate bit decides whether channel outputs reach the pins. Matching and flags run whether the gate is open or not.

Top module: `tcmp_bank`

## Requirements
- R1: After reset, every mode field, flag, enable, active compare value and the global gate read as 0. The queued slot is empty, and all pins, DMA requests and the interrupt are low.
- R2: Channel n's control/status register is at 0x608+8n and its compare register is at 0x60C+8n. In the control/status register, bit 7 is the event flag, bit 6 the interrupt enable, bits 5:2 the mode and bit 0 the DMA request enable. Bit 1 reads 0. A compare read returns the active value.
- R3: A channel with a nonzero mode matches when the time input equals its active compare value at a clock edge, and its flag is set by that same edge. A channel in mode 0 never matches.
- R4: In mode 0xF the channel output is high for exactly the one clock that follows each matching edge.
- R5: In mode 0x5 the output inverts after each matching edge. Any other nonzero mode sets the flag but keeps the output low.
- R6: A compare write while the mode is 0 loads the active value. A compare write while the mode is nonzero fills the queued slot, and a later write overwrites it. On a match with the slot full, the queued value becomes active and the slot empties. Without a queued value the active value stays.
- R7: The flag stays set until it is cleared, either by writing 1 to bit 7 of the channel's control/status register or by writing 1 to bit n of the global status register at 0x604, which shows flag n in bit n. A match in the same cycle wins over the clear.
- R8: The interrupt output is the OR over channels of flag AND interrupt enable. The DMA request for channel n is flag n AND its DMA request enable.
- R9: The global control register at 0x600 has the output gate at bit 7 and reads it back. While the gate is 0, every pin is low, but flags still set on matches.
- R10: A control/status write with mode 0 disables the channel and empties its queued slot. The output is low from the next cycle on.
- R11: Compare values are masked to 31 bits. Matching works across the wrap of the time value from 0x7FFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tc_i | input | 31 | Current time value in nanoseconds |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pin_o | output | 4 | Gated channel outputs |
| dma_req_o | output | 4 | Per-channel DMA requests |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the time input is whatever the neighbouring counter presents. They also assume that register writes are single-cycle strobes with stable address and data, and that a compare write and a control/status write to the same channel in one cycle are resolved from the mode held before that cycle. The bench drives every input one time unit after the falling edge, so the sampling edge always sees settled values. It mostly lets the time input advance by one per clock. For the wrap and same-cycle clear cases it freezes the time input or loads it just below the wrap point, so repeated matches and matches across the wrap arise on purpose and are never left to chance.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W = 4;
  localparam int CSR_W  = 8;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_OFF    = 4'h0;
  localparam mode_t MODE_TOGGLE = 4'h5;
  localparam mode_t MODE_PULSE  = 4'hF;
  localparam int BIT_DRE  = 0;
  localparam int BIT_MLO  = 2;
  localparam int BIT_IE   = 6;
  localparam int BIT_FLAG = 7;
endpackage

// File: rtl/tcmp_chan.sv
module tcmp_chan
  import tcmp_pkg::*;
#(
  parameter int TW = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tc_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wd_i,
  input  logic             cmp_we_i,
  input  logic [TW-1:0]    cmp_wd_i,
  input  logic             flag_clr_i,
  output logic [CSR_W-1:0] csr_rd_o,
  output logic [TW-1:0]    cmp_rd_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             dma_o,
  output logic             out_o
);
  mode_t         mode_q, mode_d, wr_mode;
  logic          ie_q, ie_d, dre_q, dre_d;
  logic          flag_q, flag_d, out_q, out_d;
  logic [TW-1:0] act_q, act_d, nxt_q, nxt_d;
  logic          vld_q, vld_d;
  logic          match, clr, cfg_en, cmp_en;
  logic          unused_csr_b1;

  assign unused_csr_b1 = csr_wd_i[1];

  // next-state logic
  always_comb begin
    wr_mode = mode_t'(csr_wd_i[BIT_MLO +: MODE_W]);
    match   = (mode_q != MODE_OFF) && (tc_i == act_q);
    clr     = flag_clr_i | (csr_we_i & csr_wd_i[BIT_FLAG]);
    flag_d  = match | (flag_q & ~clr);
    cfg_en  = csr_we_i;
    mode_d  = wr_mode;
    ie_d    = csr_wd_i[BIT_IE];
    dre_d   = csr_wd_i[BIT_DRE];
    unique case (mode_q)
      MODE_PULSE:  out_d = match;
      MODE_TOGGLE: out_d = out_q ^ match;
      default:     out_d = 1'b0;
    endcase
    act_d = act_q;
    nxt_d = nxt_q;
    vld_d = vld_q;
    if (match && vld_q) begin
      act_d = nxt_q;
      vld_d = 1'b0;
    end
    if (cmp_we_i) begin
      if (mode_q == MODE_OFF) begin
        act_d = cmp_wd_i;
      end else begin
        nxt_d = cmp_wd_i;
        vld_d = 1'b1;
      end
    end
    if (csr_we_i && (wr_mode == MODE_OFF)) vld_d = 1'b0;
    cmp_en = cmp_we_i | (match & vld_q) | csr_we_i;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      ie_q   <= 1'b0;
      dre_q  <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
      dre_q  <= dre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      out_q  <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      nxt_q <= '0;
      vld_q <= 1'b0;
    end else if (cmp_en) begin
      act_q <= act_d;
      nxt_q <= nxt_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    csr_rd_o                          = '0;
    csr_rd_o[BIT_FLAG]                = flag_q;
    csr_rd_o[BIT_IE]                  = ie_q;
    csr_rd_o[BIT_MLO +: MODE_W]       = mode_q;
    csr_rd_o[BIT_DRE]                 = dre_q;
  end
  assign cmp_rd_o = act_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ie_q;
  assign dma_o    = flag_q & dre_q;
  assign out_o    = out_q;

  // R3: a match raises the flag at the matching edge
  a_r3_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);
  // R10: a disabled channel drives its output low
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |=> !out_q);
  // R4: a pulse lasts one clock unless another match follows
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && (mode_q == MODE_PULSE) && !match) |=> !out_q);
  // R5: toggle mode inverts the output on a match
  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_TOGGLE) && match) |=> (out_q != $past(out_q)));
  // R6: a queued value becomes active after a match
  a_r6_reload_takes_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (match && vld_q && !cmp_we_i) |=> (act_q == $past(nxt_q)));
  // R7: the flag holds until cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/tcmp_glob.sv
module tcmp_glob #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we_i,
  input  logic           ctl_wd_i,
  input  logic           stat_we_i,
  input  logic [NCH-1:0] stat_wd_i,
  input  logic [NCH-1:0] irq_term_i,
  input  logic [NCH-1:0] out_lvl_i,
  output logic           gate_o,
  output logic [NCH-1:0] flag_clr_o,
  output logic           irq_o,
  output logic [NCH-1:0] pin_o
);
  logic gate_q, gate_d;

  always_comb begin
    gate_d = ctl_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (ctl_we_i) gate_q <= gate_d;
  end

  assign gate_o     = gate_q;
  assign flag_clr_o = stat_we_i ? stat_wd_i : '0;
  assign irq_o      = |irq_term_i;
  assign pin_o      = gate_q ? out_lvl_i : '0;
endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
  import tcmp_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int TW         = 31,
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int GCTL_ADDR  = 'h600,
  parameter int GSTAT_ADDR = 'h604,
  parameter int CH_BASE    = 'h608,
  parameter int CH_STRIDE  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  tc_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] dma_req_o,
  output logic           irq_o
);
  localparam int CMP_OFS = 4;
  localparam int GATE_BIT = 7;

  logic [NCH-1:0]   csr_we, cmp_we, flag, irq_term, dma_term, out_lvl, flag_clr;
  logic [CSR_W-1:0] csr_rd [NCH];
  logic [TW-1:0]    cmp_rd [NCH];
  logic             gate, ctl_we, stat_we;
  logic             unused_wr_hi;

  assign unused_wr_hi = wr_data_i[DW-1];
  assign ctl_we  = wr_en_i && (wr_addr_i == AW'(GCTL_ADDR));
  assign stat_we = wr_en_i && (wr_addr_i == AW'(GSTAT_ADDR));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign csr_we[g] = wr_en_i && (wr_addr_i == AW'(CH_BASE + g*CH_STRIDE));
    assign cmp_we[g] = wr_en_i && (wr_addr_i == AW'(CH_BASE + g*CH_STRIDE + CMP_OFS));
    tcmp_chan #(.TW(TW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tc_i       (tc_i),
      .csr_we_i   (csr_we[g]),
      .csr_wd_i   (wr_data_i[CSR_W-1:0]),
      .cmp_we_i   (cmp_we[g]),
      .cmp_wd_i   (wr_data_i[TW-1:0]),
      .flag_clr_i (flag_clr[g]),
      .csr_rd_o   (csr_rd[g]),
      .cmp_rd_o   (cmp_rd[g]),
      .flag_o     (flag[g]),
      .irq_o      (irq_term[g]),
      .dma_o      (dma_term[g]),
      .out_o      (out_lvl[g])
    );
  end

  tcmp_glob #(.NCH(NCH)) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we_i   (ctl_we),
    .ctl_wd_i   (wr_data_i[GATE_BIT]),
    .stat_we_i  (stat_we),
    .stat_wd_i  (wr_data_i[NCH-1:0]),
    .irq_term_i (irq_term),
    .out_lvl_i  (out_lvl),
    .gate_o     (gate),
    .flag_clr_o (flag_clr),
    .irq_o      (irq_o),
    .pin_o      (pin_o)
  );

  assign dma_req_o = dma_term;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(GCTL_ADDR))  rd_data_o[GATE_BIT] = gate;
    if (rd_addr_i == AW'(GSTAT_ADDR)) rd_data_o[NCH-1:0] = flag;
    for (int n = 0; n < NCH; n++) begin
      if (rd_addr_i == AW'(CH_BASE + n*CH_STRIDE))
        rd_data_o[CSR_W-1:0] = csr_rd[n];
      if (rd_addr_i == AW'(CH_BASE + n*CH_STRIDE + CMP_OFS))
        rd_data_o[TW-1:0] = cmp_rd[n];
    end
  end
endmodule

// File: tb/tcmp_bank_test.sv
`timescale 1ns/1ps
module tcmp_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [30:0] tc_q = '0;
  logic        tc_run = 1'b1, tc_load = 1'b0;
  logic [30:0] tc_load_val = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pin, dma;
  logic        irq;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int pulses [4];
  logic chk_on = 1'b0;

  always #4 clk = ~clk;

  tcmp_bank uut (
    .clk(clk), .rst_n(rst_n), .tc_i(tc_q), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_o(pin), .dma_req_o(dma), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (tc_load) tc_q <= tc_load_val;
    else if (tc_run) tc_q <= tc_q + 31'd1;
  end

  // behavioural reference model
  logic [3:0]  m_mode [4];
  logic        m_ie [4], m_dre [4], m_flag [4], m_out [4], m_qv [4];
  logic [30:0] m_act [4], m_q [4];
  logic        m_gate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_mode[c] = 0; m_ie[c] = 0; m_dre[c] = 0; m_flag[c] = 0;
        m_out[c] = 0; m_qv[c] = 0; m_act[c] = 0; m_q[c] = 0;
      end
      m_gate = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit hit_csr, hit_cmp, mt, clr;
        hit_csr = wr_en && (wr_addr == 12'h608 + 12'(8*c));
        hit_cmp = wr_en && (wr_addr == 12'h60C + 12'(8*c));
        mt  = (m_mode[c] != 0) && (tc_q == m_act[c]);
        clr = (wr_en && wr_addr == 12'h604 && wr_data[c]) || (hit_csr && wr_data[7]);
        m_flag[c] = mt || (m_flag[c] && !clr);
        if (m_mode[c] == 4'hF) m_out[c] = mt;
        else if (m_mode[c] == 4'h5) m_out[c] = m_out[c] ^ mt;
        else m_out[c] = 0;
        if (mt && m_qv[c]) begin m_act[c] = m_q[c]; m_qv[c] = 0; end
        if (hit_cmp) begin
          if (m_mode[c] == 0) m_act[c] = wr_data[30:0];
          else begin m_q[c] = wr_data[30:0]; m_qv[c] = 1; end
        end
        if (hit_csr) begin
          m_mode[c] = wr_data[5:2]; m_ie[c] = wr_data[6]; m_dre[c] = wr_data[0];
          if (wr_data[5:2] == 0) m_qv[c] = 0;
        end
      end
      if (wr_en && wr_addr == 12'h600) m_gate = wr_data[7];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of outputs against the model
  always @(negedge clk) begin
    if (chk_on) begin
      logic [8:0] e;
      for (int c = 0; c < 4; c++) begin
        e[c]   = m_out[c] & m_gate;
        e[4+c] = m_flag[c] & m_dre[c];
      end
      e[8] = (m_flag[0] & m_ie[0]) | (m_flag[1] & m_ie[1]) |
             (m_flag[2] & m_ie[2]) | (m_flag[3] & m_ie[3]);
      chk("R4 R5 R8 R9 per-clock outputs", {23'd0, irq, dma, pin}, {23'd0, e});
      for (int c = 0; c < 4; c++) if (pin[c]) pulses[c]++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      n_bad++;
      $display("FAIL watchdog R3 wait hung actual=%0d expected<40000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1; rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_tc(input logic [30:0] x);
    while (tc_q != x) begin @(negedge clk); #1; end
  endtask

  task automatic clr_pulses();
    for (int c = 0; c < 4; c++) pulses[c] = 0;
  endtask

  logic [30:0] t0, t1, t2, t3, tf;

  initial begin
    rst_n = 0;
    clr_pulses();
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    chk_on = 1;
    rd(12'h608, 0, "R1 csr0 reset");
    rd(12'h60C, 0, "R1 cmp0 reset");
    rd(12'h604, 0, "R1 status reset");
    rd(12'h600, 0, "R1 gate reset");
    chk("R1 outputs reset", {23'd0, irq, dma, pin}, 0);

    wr(12'h600, 32'h80);
    rd(12'h600, 32'h80, "R9 gate readback");

    // channel 0: pulse mode with one queued reload
    wr(12'h608, 0);
    t0 = tc_q + 31'd40;
    wr(12'h60C, {1'b0, t0});
    wr(12'h608, 32'h7D);
    rd(12'h608, 32'h7D, "R2 csr0 fields");
    rd(12'h60C, {1'b0, t0}, "R2 cmp0 active readback");
    wr(12'h60C, {1'b0, t0 + 31'd30});
    rd(12'h60C, {1'b0, t0}, "R6 queued value not active yet");
    clr_pulses();
    wait_tc(t0 + 31'd40);
    chk("R4 two one-clock pulses", pulses[0], 2);
    rd(12'h60C, {1'b0, t0 + 31'd30}, "R6 queued became active");
    rd(12'h604, 32'h1, "R3 flag0 set");
    chk("R8 irq with ie", irq, 1);
    chk("R8 dma with dre", dma[0], 1);
    wr(12'h608, 32'hFD);
    chk("R7 csr w1c clears irq", irq, 0);
    rd(12'h608, 32'h7D, "R7 csr w1c keeps fields");

    // channel 1: toggle mode, queue overwrite
    wr(12'h610, 0);
    t1 = tc_q + 31'd40;
    wr(12'h614, {1'b0, t1});
    wr(12'h610, 32'h15);
    wr(12'h614, {1'b0, t1 + 31'd20});
    wr(12'h614, {1'b0, t1 + 31'd25});
    wait_tc(t1 + 31'd10);
    chk("R5 toggle high after first match", pin[1], 1);
    wait_tc(t1 + 31'd30);
    chk("R5 toggle low after second match", pin[1], 0);
    rd(12'h614, {1'b0, t1 + 31'd25}, "R6 second queued write overwrote");
    chk("R8 dma1 with dre", dma[1], 1);
    chk("R8 no irq without ie", irq, 0);
    wr(12'h604, 32'h2);
    rd(12'h604, 0, "R7 status w1c clears flag1");

    // gate closed: pulses blocked, flags still set; other mode flags only
    wr(12'h600, 0);
    wr(12'h618, 0);
    t2 = tc_q + 31'd40;
    wr(12'h61C, {1'b0, t2});
    wr(12'h618, 32'h4C);
    wr(12'h608, 0);
    wr(12'h60C, {1'b0, t2 + 31'd5});
    wr(12'h608, 32'h3C);
    clr_pulses();
    wait_tc(t2 + 31'd15);
    chk("R9 no pin pulse with gate closed", pulses[0], 0);
    chk("R5 other mode keeps output low", pulses[2], 0);
    rd(12'h604, 32'h5, "R9 flags set while gated");
    chk("R8 irq from channel 2", irq, 1);
    wr(12'h604, 32'h5);
    rd(12'h604, 0, "R7 status clears two flags");
    wr(12'h600, 32'h80);

    // disable empties the queue
    t3 = tc_q + 31'd40;
    wr(12'h60C, {1'b0, t3});
    wr(12'h608, 0);
    wr(12'h608, 32'h3C);
    clr_pulses();
    wait_tc(t3 + 31'd5);
    chk("R10 disable dropped queued event", pulses[0], 0);
    rd(12'h60C, {1'b0, t2 + 31'd5}, "R10 active unchanged");

    // mode 0 never matches
    wr(12'h624, {1'b0, tc_q + 31'd10});
    wait_tc(tc_q + 31'd20);
    rd(12'h604, 0, "R3 mode 0 raises no flag");

    // frozen time: match each cycle wins over clear
    @(negedge clk); #1 tc_run = 0;
    @(negedge clk); #1 tf = tc_q;
    wr(12'h618, 0);
    wr(12'h61C, {1'b0, tf});
    wr(12'h618, 32'h4C);
    wr(12'h618, 32'hCC);
    rd(12'h604, 32'h4, "R7 match beats clear");
    wr(12'h618, 0);
    wr(12'h604, 32'h4);
    rd(12'h604, 0, "R7 clear after disable");

    // wrap of the time value
    tc_load_val = 31'h7FFFFFF0;
    @(negedge clk); #1 tc_load = 1;
    @(negedge clk); #1 tc_load = 0;
    wr(12'h620, 0);
    wr(12'h624, 32'hFFFFFFF8);
    rd(12'h624, 32'h7FFFFFF8, "R11 compare masked to 31 bits");
    wr(12'h620, 32'h3C);
    wr(12'h624, 32'h4);
    clr_pulses();
    @(negedge clk); #1 tc_run = 1;
    wait_tc(31'd10);
    chk("R11 pulses before and after wrap", pulses[3], 2);
    rd(12'h624, 32'h4, "R11 post-wrap value active");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule